// File: doc/BRIEF.md
# Clock Divider-Multiplexer-Gate Channel

This block is one output channel of a clock generator. It takes three free-running source clocks and drives a single output clock. A register interface in the system clock domain controls the channel. A two-bit select field picks which source feeds the output. Select code 3 stops the output, so the same field serves as the channel gate. Each source has its own five-bit divide ratio. The ratio that applies is always the one that belongs to the source currently selected.

The channel switches between sources without glitches. The path that is being deselected is shut while its clock is low. The next path is opened only after the previous path has confirmed, through synchronizers, that it is shut. A divide ratio written while the channel is running takes effect at the next boundary of a divided period.

Each source also has a read-only running bit, which comes back through the register interface. Software enables the channel by writing a source index and then polling until the matching running bit reads 1. It disables the channel by writing 3.

Top module: `clk_divmux_chan`

## Requirements
- R1: After reset, the select field reads 3, all three divide fields read 0, all running bits read 0, and `clk_o` stays low.
- R2: A write to address 0 loads the select field from data bits [1:0]. A read of address 0 returns the select field in bits [1:0], the running bits of sources 0, 1 and 2 in bits 4, 5 and 6, and zeros elsewhere. Addresses 1, 2 and 3 hold the divide fields of sources 0, 1 and 2 in bits [4:0], and each field reads back what was last written to it.
- R3: A divide field of 0 passes the selected source through unchanged: same period and same high time.
- R4: A divide field N > 0 gives an output period of N+1 source periods. The output is high for floor((N+1)/2) source periods and low for the remainder.
- R5: Each source keeps its own divide field. Writing the field of a source that is not selected leaves the output unchanged, and the stored value is applied once that source is selected.
- R6: After a switch to source i, the running bit of source i reads 1 and all other running bits read 0.
- R7: Select code 3 stops `clk_o` low and clears all running bits.
- R8: A new divide value written while the channel is running is applied only when a divided period wraps. No output phase becomes shorter than half a period of the source.
- R9: A source switch never enables two paths at once. The old path is stopped in its low phase, and the output shows no pulse or gap shorter than half a period of the faster source.
- R10: Writes to bits [6:4] of address 0 have no effect: the running bits keep reporting the hardware state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset for all domains |
| src_clk_i | input | NUM_SRC (3) | Source clocks; bit i is source i |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (2) | Write address: 0 select, 1..3 divide fields |
| wr_data_i | input | DATA_W (8) | Write data |
| rd_addr_i | input | ADDR_W (2) | Read address |
| rd_data_o | output | DATA_W (8) | Read data, combinational from `rd_addr_i` |
| clk_o | output | 1 | Gated, divided output clock |

## Verification
The output clock is measured in period and high time under several conditions:
- pass-through on the fastest source, which separates R3 from the divide path;
- an even ratio and an odd ratio, which show the high-time rounding of R4;
- a ratio written to an unselected source, which must leave the measured period untouched (R5) until that source is selected;
- switches across all three sources, whose distinct periods reveal a path picked from the wrong divide field.

A pulse-width monitor runs throughout, so a short phase produced by a switch or a ratio change is caught even when the settled period is correct. Gating off is shown by an edge count that stays constant while the select field holds 3.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
    // Default geometry of one channel
    localparam int unsigned CDM_NUM_SRC = 3;
    localparam int unsigned CDM_DIV_W   = 5;
    localparam int unsigned CDM_DATA_W  = 8;
    // First bit of the running flags in the select/status word
    localparam int unsigned CDM_RUN_LSB = 4;
endpackage

// File: rtl/cdm_sync.sv
// Multi-stage level synchronizer, reset to zero.
module cdm_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cdm_regs.sv
// Select and divide registers plus the read multiplexer.
module cdm_regs #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned DIV_W   = 5,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned RUN_LSB = 4
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [DATA_W-1:0]               wr_data_i,
    input  logic [ADDR_W-1:0]               rd_addr_i,
    input  logic [NUM_SRC-1:0]              run_i,
    output logic [DATA_W-1:0]               rd_data_o,
    output logic [SEL_W-1:0]                sel_o,
    output logic [NUM_SRC-1:0][DIV_W-1:0]   div_o
);
    typedef struct packed {
        logic [SEL_W-1:0]              sel;
        logic [NUM_SRC-1:0][DIV_W-1:0] div;
    } regs_t;

    regs_t st_d, st_q;

    // Upper write-data bits carry no field
    logic unused_wdata;
    assign unused_wdata = ^wr_data_i[DATA_W-1:DIV_W];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (wr_addr_i == '0) begin
                st_d.sel = wr_data_i[SEL_W-1:0];
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_addr_i == ADDR_W'(i + 1)) begin
                    st_d.div[i] = wr_data_i[DIV_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.sel <= '1;   // all ones: output off
            st_q.div <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == '0) begin
            rd_data_o[SEL_W-1:0]          = st_q.sel;
            rd_data_o[RUN_LSB +: NUM_SRC] = run_i;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (rd_addr_i == ADDR_W'(i + 1)) begin
                    rd_data_o[DIV_W-1:0] = st_q.div[i];
                end
            end
        end
    end

    assign sel_o = st_q.sel;
    assign div_o = st_q.div;
endmodule

// File: rtl/cdm_path.sv
// One source path: divide counter, ratio capture and falling-edge gate.
module cdm_path #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             src_clk_i,
    input  logic             rst_ni,
    input  logic             req_i,     // asynchronous enable request
    input  logic [DIV_W-1:0] ratio_i,   // asynchronous divide field
    output logic             gate_o,
    output logic             clk_o
);
    typedef struct packed {
        logic [DIV_W-1:0] prev;   // last synchronized ratio sample
        logic [DIV_W-1:0] pend;   // ratio seen stable, waiting for a wrap
        logic [DIV_W-1:0] nact;   // ratio in force
        logic [DIV_W-1:0] cnt;
        logic             div;    // divided level
    } path_t;

    path_t            st_d, st_q;
    logic [DIV_W-1:0] ratio_s;
    logic             req_s;
    logic             gate_d, gate_q;
    logic [DIV_W:0]   half;

    cdm_sync #(.W(DIV_W), .STAGES(2)) u_ratio_sync (
        .clk_i (src_clk_i),
        .rst_ni(rst_ni),
        .d_i   (ratio_i),
        .q_o   (ratio_s)
    );

    cdm_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk_i (src_clk_i),
        .rst_ni(rst_ni),
        .d_i   (req_i),
        .q_o   (req_s)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = ratio_s;
        // Two equal consecutive samples: bus has settled
        if (ratio_s == st_q.prev) begin
            st_d.pend = ratio_s;
        end
        if (st_q.cnt == st_q.nact) begin
            st_d.cnt  = '0;
            st_d.nact = st_q.pend;
        end else begin
            st_d.cnt  = st_q.cnt + DIV_W'(1);
        end
        half     = ({1'b0, st_d.nact} + (DIV_W+1)'(1)) >> 1;
        st_d.div = ({1'b0, st_d.cnt} < half);
        // Gate may move only while the path output is low
        gate_d   = ((st_q.nact == '0) || !st_q.div) ? req_s : gate_q;
    end

    always_ff @(posedge src_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(negedge src_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= gate_d;
        end
    end

    // Observation points also used by the bound checker
    logic [DIV_W-1:0] nact_w, cnt_w;
    logic             div_w;
    assign nact_w = st_q.nact;
    assign cnt_w  = st_q.cnt;
    assign div_w  = st_q.div;

    assign gate_o = gate_q;
    assign clk_o  = ((nact_w == '0) ? src_clk_i : div_w) & gate_q;
endmodule

// File: rtl/clk_divmux_chan.sv
// Clock divider-multiplexer-gate channel, top level.
module clk_divmux_chan
    import cdm_pkg::*;
#(
    parameter int unsigned NUM_SRC = CDM_NUM_SRC,
    parameter int unsigned DIV_W   = CDM_DIV_W,
    parameter int unsigned DATA_W  = CDM_DATA_W,
    localparam int unsigned SEL_W  = $clog2(NUM_SRC + 1),
    localparam int unsigned ADDR_W = $clog2(NUM_SRC + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               clk_o
);
    logic [SEL_W-1:0]              sel_w;
    logic [NUM_SRC-1:0][DIV_W-1:0] div_w;
    logic [NUM_SRC-1:0]            gate_w, req_w, path_clk_w, run_w;

    cdm_regs #(
        .NUM_SRC(NUM_SRC), .DIV_W(DIV_W), .SEL_W(SEL_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RUN_LSB(CDM_RUN_LSB)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i),
        .run_i    (run_w),
        .rd_data_o(rd_data_o),
        .sel_o    (sel_w),
        .div_o    (div_w)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_path
        // Request only once every other path reports its gate shut
        assign req_w[i] = (sel_w == SEL_W'(i)) &&
                          !(|(gate_w & ~(NUM_SRC'(1) << i)));

        cdm_path #(.DIV_W(DIV_W)) u_path (
            .src_clk_i(src_clk_i[i]),
            .rst_ni   (rst_ni),
            .req_i    (req_w[i]),
            .ratio_i  (div_w[i]),
            .gate_o   (gate_w[i]),
            .clk_o    (path_clk_w[i])
        );
    end

    cdm_sync #(.W(NUM_SRC), .STAGES(2)) u_run_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (gate_w),
        .q_o   (run_w)
    );

    assign clk_o = |path_clk_w;
endmodule

// File: rtl/clk_divmux_chan_chk.sv
module clk_divmux_chan_chk #(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  wr_addr_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic [SEL_W-1:0]   sel_w,
    input logic [NUM_SRC-1:0] gate_w
);
    AST_ONE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gate_w)); // R9

    AST_SEL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == '0) |=> (sel_w == $past(wr_data_i[SEL_W-1:0]))); // R2
endmodule

module cdm_path_chk #(
    parameter int unsigned DIV_W = 5
) (
    input logic             src_clk_i,
    input logic             rst_ni,
    input logic [DIV_W-1:0] cnt_i,
    input logic [DIV_W-1:0] nact_i,
    input logic             div_i,
    input logic             gate_i
);
    AST_CNT_BOUND: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
        cnt_i <= nact_i); // R4

    AST_GATE_LOW: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
        !$stable(gate_i) |-> (nact_i == '0 || !div_i)); // R9

    AST_LOAD_WRAP: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
        !$stable(nact_i) |-> ($past(cnt_i) == $past(nact_i))); // R8
endmodule

bind clk_divmux_chan clk_divmux_chan_chk #(
    .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chan_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .sel_w    (sel_w),
    .gate_w   (gate_w)
);

bind cdm_path cdm_path_chk #(.DIV_W(DIV_W)) u_path_chk (
    .src_clk_i(src_clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt_w),
    .nact_i   (nact_w),
    .div_i    (div_w),
    .gate_i   (gate_q)
);

// File: tb/clk_divmux_chan_bench.sv
// One time unit is taken as 1 ns; clk runs at 100 MHz.
module clk_divmux_chan_bench;
    localparam int P0 = 6;
    localparam int P1 = 14;
    localparam int P2 = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_clk = 3'b000;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       clk_out;

    int ntests = 0;
    int nfail  = 0;
    int nedge  = 0;
    int nglitch = 0;
    longint t_rise = -1;
    longint t_fall = -1;

    // Scoreboard queues: expected period, expected high time, requirement
    int    exp_per_q[$];
    int    exp_hi_q[$];
    string exp_tag_q[$];

    clk_divmux_chan u_clk_divmux_chan (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .src_clk_i(src_clk),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data),
        .clk_o    (clk_out)
    );

    always #5 clk = ~clk;
    initial forever #(P0/2) src_clk[0] = ~src_clk[0];
    initial begin #1; forever #(P1/2) src_clk[1] = ~src_clk[1]; end
    initial begin #2; forever #(P2/2) src_clk[2] = ~src_clk[2]; end

    task automatic chk(input bit ok, input string req, input longint act,
                       input longint exp, input string what);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    endtask

    // Pulse-width monitor: no phase shorter than the narrowest half period
    always @(posedge clk_out) begin
        nedge++;
        if (t_fall >= 0 && ($time - t_fall) < P0/2) nglitch++;
        t_rise = $time;
    end
    always @(negedge clk_out) begin
        if (t_rise >= 0 && ($time - t_rise) < P0/2) nglitch++;
        t_fall = $time;
    end

    // Monitor: pops an expectation and measures one output period
    initial begin
        forever begin
            longint t0, t1, t2;
            wait (exp_per_q.size() != 0);
            @(posedge clk_out); t0 = $time;
            @(negedge clk_out); t1 = $time;
            @(posedge clk_out); t2 = $time;
            chk((t2 - t0) == exp_per_q[0], exp_tag_q[0], t2 - t0, exp_per_q[0], "period");
            chk((t1 - t0) == exp_hi_q[0], exp_tag_q[0], t1 - t0, exp_hi_q[0], "high time");
            void'(exp_per_q.pop_front());
            void'(exp_hi_q.pop_front());
            void'(exp_tag_q.pop_front());
        end
    end

    task automatic expect_clk(input int per, input int hi, input string tag);
        exp_per_q.push_back(per);
        exp_hi_q.push_back(hi);
        exp_tag_q.push_back(tag);
        wait (exp_per_q.size() == 0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (200) @(negedge clk);
    endtask

    task automatic wait_run(input logic [2:0] exp, input string req);
        logic [7:0] d;
        int n = 0;
        do begin
            rd(2'd0, d);
            n++;
        end while (d[6:4] != exp && n < 400);
        chk(d[6:4] == exp, req, d[6:4], exp, "running bits");
    endtask

    task automatic no_edges(input string req);
        int e0;
        e0 = nedge;
        #600;
        chk(nedge == e0, req, nedge - e0, 0, "output edges while off");
    endtask

    initial begin
        #1500000;
        nfail++;
        $display("FAIL watchdog expired: actual hang expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: reset state
        rd(2'd0, d);
        chk(d == 8'h03, "R1", d, 8'h03, "select/status after reset");
        for (int i = 1; i <= 3; i++) begin
            rd(2'(i), d);
            chk(d == 8'h00, "R1", d, 0, "divide field after reset");
        end
        no_edges("R1");

        // R2: register readback
        wr(2'd2, 8'h04);
        rd(2'd2, d);
        chk(d == 8'h04, "R2", d, 8'h04, "divide field 1 readback");
        wr(2'd2, 8'h00);

        // R3: pass-through of source 0
        wr(2'd0, 8'h00);
        wait_run(3'b001, "R6");
        settle();
        expect_clk(P0, P0/2, "R3");

        // R8: ratio changes while running, R4: divided shapes
        int_ratio_block: begin
            int g0;
            g0 = nglitch;
            wr(2'd1, 8'h03);
            settle();
            expect_clk(4*P0, 2*P0, "R4");
            wr(2'd1, 8'h02);
            settle();
            expect_clk(3*P0, P0, "R8");
            chk(nglitch == g0, "R8", nglitch - g0, 0, "short phases at ratio change");
        end

        // R10: status bits are read-only
        wr(2'd0, 8'h70);
        rd(2'd0, d);
        chk(d == 8'h10, "R10", d, 8'h10, "status after write to status bits");

        // R5: writing an unselected source's ratio does not disturb output
        wr(2'd2, 8'h04);
        settle();
        expect_clk(3*P0, P0, "R5");

        // R9/R6: switch to source 1, its stored ratio applies
        wr(2'd0, 8'h01);
        wait_run(3'b010, "R6");
        settle();
        expect_clk(5*P1, 2*P1, "R5");

        // switch to source 2 with ratio 1
        wr(2'd3, 8'h01);
        wr(2'd0, 8'h02);
        wait_run(3'b100, "R6");
        settle();
        expect_clk(2*P2, P2, "R4");

        rd(2'd2, d);
        chk(d == 8'h04, "R5", d, 8'h04, "source 1 ratio retained");

        // R7: gate off
        wr(2'd0, 8'h03);
        wait_run(3'b000, "R7");
        no_edges("R7");

        // back to source 0, ratio kept from before
        wr(2'd0, 8'h00);
        wait_run(3'b001, "R6");
        settle();
        expect_clk(3*P0, P0, "R9");

        chk(nglitch == 0, "R9", nglitch, 0, "short output phases overall");

        summary();
        $finish;
    end
endmodule